// File: doc/BRIEF.md
# Two-Level Priority Interrupt Controller

This block sits beside a small CPU core and decides which of up to 21 maskable interrupt sources the core should service next. Every source brings a level-sensitive pending flag, and the core's register file supplies one enable bit and one priority bit per source, plus a global enable. The block masks the flags, splits the surviving requests into a high group and a low group, and picks a winner. Within a group the lowest source index wins. It then presents a registered request together with the handler address of the winner.

The core reports two events. The first is a vector-taken strobe, issued when it branches to the presented handler. The second is a return strobe, issued when a handler finishes. The block keeps one in-service bit per priority level. A low-level handler can therefore be pre-empted by a high-level request, and nothing interrupts a high-level handler. When a vector is taken, the block also pulses a one-hot acknowledge to the winning source for one cycle. A source that clears its flag in hardware can use this pulse to do so.

Top module: `irqc_top`

## Requirements
- R1: While a request is presented, `vec_o` equals 3 + 8·n (16 bits), where n is the winning source's index. While no request is presented, `vec_o` is 0.
- R2: Source n can request only when `pend_i[n]`, `en_i[n]` and `gen_en_i` are all 1. A pending flag whose source is disabled, or any flag while `gen_en_i` is 0, has no effect on `irq_o` or `vec_o`.
- R3: `prio_i[n]`=1 places source n in the high level and 0 places it in the low level. Any eligible high-level source beats every low-level source.
- R4: Among eligible sources of the same level, the lowest index wins.
- R5: While only a low-level handler is in service, eligible high-level requests are presented and low-level requests are withheld.
- R6: While a high-level handler is in service, no request is presented.
- R7: A `reti_i` pulse clears the high in-service bit if it is set, otherwise the low one. A flag still pending and eligible is presented again on the cycle after the return.
- R8: A `vec_ack_i` pulse while `irq_o`=1 marks the presented source's level as in service. It also drives `src_ack_o` one-hot on that source's bit for exactly one cycle. A `vec_ack_i` while `irq_o`=0 is ignored.
- R9: While `rst_ni` is 0, `irq_o`, `vec_o` and `src_ack_o` are 0, whatever the inputs are. Both in-service bits reset to clear.
- R10: All outputs are registered. A change on the inputs becomes visible only after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pend_i | input | 21 | Level-sensitive pending flags, one per source |
| en_i | input | 21 | Individual enable bits |
| prio_i | input | 21 | Priority bits (1 = high level) |
| gen_en_i | input | 1 | Global enable |
| vec_ack_i | input | 1 | Core has branched to the presented vector |
| reti_i | input | 1 | Core has returned from a handler |
| irq_o | output | 1 | Request presented to the core |
| vec_o | output | 16 | Handler address of the presented source |
| src_ack_o | output | 21 | One-cycle acknowledge to the source taken |

## Verification
The bound checker checks the following on every cycle:
- Any presented vector lies on the 8-byte grid of valid sources.
- A request never appears without global enable.
- Nothing is presented while a high-level handler is in service.
- The source acknowledge is one-hot and caused by a vector-taken strobe on a live request.
- A return from a high-level handler leaves the low in-service bit untouched.

The following depend on the state built up over a sequence of events, so only the directed scenarios can show them:
- The choice of the right winner among mixed levels and indices.
- Pre-emption of a low handler followed by unwinding in the correct order.
- A request raised again after a return while its flag is still pending.
- A stray acknowledge being ignored.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    // Level of the source granted in the presented request
    typedef enum logic [1:0] {
        LVL_NONE = 2'd0,
        LVL_LOW  = 2'd1,
        LVL_HIGH = 2'd2
    } lvl_e;

    // Handler address for a source index on a fixed grid
    function automatic logic [31:0] grid_addr(input int unsigned idx,
                                              input int unsigned base,
                                              input int unsigned stride);
        return 32'(base + stride * idx);
    endfunction

endpackage

// File: rtl/irqc_level_split.sv
module irqc_level_split #(
    parameter int unsigned NUM_SRC = 21
) (
    input  logic [NUM_SRC-1:0] pend_i,
    input  logic [NUM_SRC-1:0] en_i,
    input  logic [NUM_SRC-1:0] prio_i,
    input  logic               gen_en_i,
    output logic [NUM_SRC-1:0] req_hi_o,
    output logic [NUM_SRC-1:0] req_lo_o
);

    // Per-source masking and level sorting
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        logic live;
        assign live        = gen_en_i & pend_i[g] & en_i[g];
        assign req_hi_o[g] = live &  prio_i[g];
        assign req_lo_o[g] = live & ~prio_i[g];
    end

endmodule

// File: rtl/irqc_pick.sv
module irqc_pick #(
    parameter int unsigned NUM_SRC = 21,
    localparam int unsigned IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic [NUM_SRC-1:0] req_i,
    output logic               found_o,
    output logic [IDX_W-1:0]   idx_o
);

    // Fixed order: scan from the top so the lowest index is written last
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                found_o = 1'b1;
                idx_o   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int unsigned NUM_SRC    = 21,
    parameter int unsigned ADDR_W     = 16,
    parameter int unsigned VEC_BASE   = 3,
    parameter int unsigned VEC_STRIDE = 8
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_SRC-1:0] pend_i,
    input  logic [NUM_SRC-1:0] en_i,
    input  logic [NUM_SRC-1:0] prio_i,
    input  logic               gen_en_i,
    input  logic               vec_ack_i,
    input  logic               reti_i,
    output logic               irq_o,
    output logic [ADDR_W-1:0]  vec_o,
    output logic [NUM_SRC-1:0] src_ack_o
);

    localparam int unsigned IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    typedef struct packed {
        logic               isv_lo;
        logic               isv_hi;
        logic               irq;
        lvl_e               g_lvl;
        logic [IDX_W-1:0]   idx;
        logic [ADDR_W-1:0]  vec;
        logic [NUM_SRC-1:0] sack;
    } st_t;

    st_t st_d, st_q;

    logic [NUM_SRC-1:0] req_hi, req_lo;
    logic               hi_found, lo_found;
    logic [IDX_W-1:0]   hi_idx, lo_idx;

    irqc_level_split #(.NUM_SRC(NUM_SRC)) split_i (
        .pend_i   (pend_i),
        .en_i     (en_i),
        .prio_i   (prio_i),
        .gen_en_i (gen_en_i),
        .req_hi_o (req_hi),
        .req_lo_o (req_lo)
    );

    irqc_pick #(.NUM_SRC(NUM_SRC)) pick_hi_i (
        .req_i   (req_hi),
        .found_o (hi_found),
        .idx_o   (hi_idx)
    );

    irqc_pick #(.NUM_SRC(NUM_SRC)) pick_lo_i (
        .req_i   (req_lo),
        .found_o (lo_found),
        .idx_o   (lo_idx)
    );

    always_comb begin
        st_d      = st_q;
        st_d.sack = '0;

        // Return from handler unwinds the innermost level first
        if (reti_i) begin
            if (st_q.isv_hi) begin
                st_d.isv_hi = 1'b0;
            end else begin
                st_d.isv_lo = 1'b0;
            end
        end

        // Vector taken: only meaningful on a live presented request
        if (vec_ack_i && st_q.irq) begin
            for (int i = 0; i < NUM_SRC; i++) begin
                st_d.sack[i] = (st_q.idx == IDX_W'(i));
            end
            if (st_q.g_lvl == LVL_HIGH) begin
                st_d.isv_hi = 1'b1;
            end else begin
                st_d.isv_lo = 1'b1;
            end
        end

        // Arbitrate against the updated in-service state
        if (!st_d.isv_hi && hi_found) begin
            st_d.irq   = 1'b1;
            st_d.g_lvl = LVL_HIGH;
            st_d.idx   = hi_idx;
        end else if (!st_d.isv_hi && !st_d.isv_lo && lo_found) begin
            st_d.irq   = 1'b1;
            st_d.g_lvl = LVL_LOW;
            st_d.idx   = lo_idx;
        end else begin
            st_d.irq   = 1'b0;
            st_d.g_lvl = LVL_NONE;
            st_d.idx   = '0;
        end

        st_d.vec = st_d.irq
                 ? ADDR_W'(grid_addr(32'(st_d.idx), VEC_BASE, VEC_STRIDE))
                 : '0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{isv_lo: 1'b0, isv_hi: 1'b0, irq: 1'b0, g_lvl: LVL_NONE,
                      idx: '0, vec: '0, sack: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_o     = st_q.irq;
    assign vec_o     = st_q.vec;
    assign src_ack_o = st_q.sack;

endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
    parameter int unsigned NUM_SRC    = 21,
    parameter int unsigned ADDR_W     = 16,
    parameter int unsigned VEC_BASE   = 3,
    parameter int unsigned VEC_STRIDE = 8
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               gen_en_i,
    input logic               vec_ack_i,
    input logic               reti_i,
    input logic               irq_i,
    input logic [ADDR_W-1:0]  vec_i,
    input logic [NUM_SRC-1:0] sack_i,
    input logic               isv_hi_i,
    input logic               isv_lo_i
);

    p_vec_grid_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_i |-> ((int'(vec_i) >= int'(VEC_BASE)) &&
                   (((int'(vec_i) - int'(VEC_BASE)) % int'(VEC_STRIDE)) == 0) &&
                   (((int'(vec_i) - int'(VEC_BASE)) / int'(VEC_STRIDE)) < int'(NUM_SRC))));

    p_gate_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_i |-> $past(gen_en_i));

    p_hi_blocks_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        isv_hi_i |-> !irq_i);

    p_reti_unwind_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(reti_i && isv_hi_i) |-> (!isv_hi_i && (isv_lo_i == $past(isv_lo_i))));

    p_ack_onehot_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(sack_i));

    p_ack_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|sack_i) |-> $past(vec_ack_i && irq_i));

    p_isv_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($rose(isv_lo_i) || $rose(isv_hi_i)) |-> $past(vec_ack_i && irq_i));

endmodule

bind irqc_top irqc_chk #(
    .NUM_SRC    (NUM_SRC),
    .ADDR_W     (ADDR_W),
    .VEC_BASE   (VEC_BASE),
    .VEC_STRIDE (VEC_STRIDE)
) chk_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .gen_en_i  (gen_en_i),
    .vec_ack_i (vec_ack_i),
    .reti_i    (reti_i),
    .irq_i     (irq_o),
    .vec_i     (vec_o),
    .sack_i    (src_ack_o),
    .isv_hi_i  (st_q.isv_hi),
    .isv_lo_i  (st_q.isv_lo)
);

// File: tb/irqc_top_tb_top.sv
`timescale 1ns/1ps
module irqc_top_tb_top;

    localparam int N = 21;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] pend = '0, en = '0, prio = '0;
    logic         gen = 1'b0, ack = 1'b0, reti = 1'b0;
    logic         irq;
    logic [15:0]  vec;
    logic [N-1:0] sack;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    irqc_top dut_i (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .pend_i    (pend),
        .en_i      (en),
        .prio_i    (prio),
        .gen_en_i  (gen),
        .vec_ack_i (ack),
        .reti_i    (reti),
        .irq_o     (irq),
        .vec_o     (vec),
        .src_ack_o (sack)
    );

    function automatic logic [15:0] addr_of(input int i);
        return 16'(3 + 8 * i);
    endfunction

    function automatic logic [N-1:0] bit_of(input int i);
        return N'(1) << i;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Wait to a posedge and sample just after it
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic expect_req(input string req, input int src);
        check({req, " irq"}, 32'(irq), 32'd1);
        check({req, " vec"}, 32'(vec), 32'(addr_of(src)));
    endtask

    task automatic expect_idle(input string req);
        check({req, " irq"}, 32'(irq), 32'd0);
        check({req, " vec"}, 32'(vec), 32'd0);
    endtask

    // One-cycle core strobes
    task automatic pulse_ack();
        @(negedge clk); ack = 1'b1;
        step();
        @(negedge clk); ack = 1'b0;
    endtask

    task automatic pulse_reti();
        @(negedge clk); reti = 1'b1;
        step();
        @(negedge clk); reti = 1'b0;
    endtask

    task automatic t_reset();
        pend = '1; en = '1; gen = 1'b1; ack = 1'b1; reti = 1'b0;
        repeat (3) step();
        expect_idle("R9 in reset");
        check("R9 src_ack in reset", 32'(sack), 32'd0);
        @(negedge clk);
        pend = '0; en = '0; gen = 1'b0; ack = 1'b0;
        rst_n = 1'b1;
        step();
        expect_idle("R9 after reset");
    endtask

    task automatic t_vectors();
        for (int i = 0; i < N; i++) begin
            @(negedge clk);
            gen = 1'b1; pend = bit_of(i); en = bit_of(i);
            prio = (i % 2 == 1) ? bit_of(i) : '0;
            step();
            expect_req("R1 vector", i);
        end
        @(negedge clk); pend = '0; en = '0; prio = '0;
        step();
        expect_idle("R1 idle");
    endtask

    task automatic t_latency();
        @(negedge clk); pend = bit_of(8); en = '1; gen = 1'b1;
        #1;
        check("R10 before edge", 32'(irq), 32'd0);
        step();
        expect_req("R10 after edge", 8);
        @(negedge clk); pend = '0;
        step();
    endtask

    task automatic t_mask();
        @(negedge clk); pend = '1; en = '0; gen = 1'b1;
        step();
        expect_idle("R2 none enabled");
        @(negedge clk); en = '1; gen = 1'b0;
        step();
        expect_idle("R2 global off");
        @(negedge clk); gen = 1'b1; en = ~bit_of(0); pend = bit_of(0) | bit_of(5);
        step();
        expect_req("R2 disabled flag skipped", 5);
        @(negedge clk); pend = '0; en = '1;
        step();
    endtask

    task automatic t_order();
        @(negedge clk); pend = bit_of(7) | bit_of(12) | bit_of(3); prio = '0;
        step();
        expect_req("R4 lowest index", 3);
        @(negedge clk); prio = bit_of(12) | bit_of(7);
        step();
        expect_req("R3 R4 high group lowest", 7);
        @(negedge clk); pend = bit_of(0) | bit_of(20); prio = bit_of(20);
        step();
        expect_req("R3 high beats index", 20);
        @(negedge clk); pend = '0; prio = '0;
        step();
    endtask

    task automatic t_nest();
        @(negedge clk); prio = bit_of(9) | bit_of(11); pend = bit_of(2);
        step();
        expect_req("R5 low presented", 2);
        @(negedge clk); ack = 1'b1;
        step();
        check("R8 ack pulse src2", 32'(sack), 32'(bit_of(2)));
        check("R8 same level blocked", 32'(irq), 32'd0);
        @(negedge clk); ack = 1'b0; pend = bit_of(4);
        step();
        check("R8 pulse one cycle", 32'(sack), 32'd0);
        expect_idle("R5 low withheld");
        @(negedge clk); pend = bit_of(4) | bit_of(9);
        step();
        expect_req("R5 high pre-empts", 9);
        @(negedge clk); ack = 1'b1;
        step();
        check("R8 ack pulse src9", 32'(sack), 32'(bit_of(9)));
        @(negedge clk); ack = 1'b0; pend = bit_of(4) | bit_of(11);
        step();
        expect_idle("R6 high in service");
        pulse_reti();
        expect_req("R7 high again after return", 11);
        pulse_ack();
        @(negedge clk); pend = bit_of(4);
        pulse_reti();
        expect_idle("R7 back to low level");
        pulse_reti();
        expect_req("R7 low after second return", 4);
        pulse_ack();
        @(negedge clk); pend = '0; prio = '0;
        pulse_reti();
        expect_idle("R7 all unwound");
    endtask

    task automatic t_reti_repeat();
        @(negedge clk); pend = bit_of(1);
        step();
        expect_req("R7 first", 1);
        pulse_ack();
        expect_idle("R7 while serviced");
        @(negedge clk); reti = 1'b1;
        step();
        expect_req("R7 uncleared flag re-raised", 1);
        @(negedge clk); reti = 1'b0;
        pulse_ack();
        @(negedge clk); pend = '0;
        pulse_reti();
        expect_idle("R7 idle");
    endtask

    task automatic t_stray();
        @(negedge clk); pend = '0; ack = 1'b1;
        step();
        check("R8 stray ack no pulse", 32'(sack), 32'd0);
        @(negedge clk); ack = 1'b0; pend = bit_of(6);
        step();
        expect_req("R8 stray ack left nothing in service", 6);
        @(negedge clk); pend = '0;
        step();
    endtask

    initial begin
        t_reset();
        t_vectors();
        t_latency();
        t_mask();
        t_order();
        t_nest();
        t_reti_repeat();
        t_stray();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule